// File: doc/BRIEF.md
# Periodic ADC Conversion Sequencer

This block runs a parallel-bus analog-to-digital converter from the fast system clock. The converter has a start/write strobe, an 8-bit data bus, and an active-low end-of-conversion interrupt. A one-cycle sample-enable pulse in the same clock domain starts the sequence. That pulse comes from a rate divider elsewhere, for example at 5 Hz, so no second clock is ever created.

Once started, the sequencer raises the write strobe and holds it until it sees a falling edge on the synchronized interrupt. In stream mode it then pauses for a fixed settle time of ten cycles. Next it pulses the read strobe for one cycle and captures the data bus in reversed bit order. It then goes back to start the next conversion. Each captured byte leaves the block with a one-cycle valid pulse.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset, `adcWr`, `adcRd` and `sampleValid` are 0 and `sampleOut` is 0. The block stays idle with `adcWr` low until a `sampleTick` pulse arrives.
- R2: `adcWr` is first observed high two clock edges after the edge that samples a `sampleTick` pulse. It stays high while the block waits for the interrupt.
- R3: `adcIntN` passes through a two-stage synchronizer. Only a high-to-low transition of `adcIntN` ends the wait. With `streamMode` = 0, `adcRd` is high in the third cycle after the edge that first samples the low level.
- R4: With `streamMode` = 1, the read is delayed by exactly ten further cycles. During those cycles `adcWr` and `adcRd` are both 0.
- R5: `adcRd` is high for exactly one cycle. In the next cycle `adcWr` is high again and the next conversion starts.
- R6: On a read, `sampleOut` loads `adcData` bit-reversed: bus bit i becomes output bit 7-i.
- R7: `sampleValid` pulses for one cycle, in the cycle right after `adcRd`, and `sampleOut` holds the new byte at that time.
- R8: After the first start, conversions repeat without waiting for further ticks. `sampleTick` pulses that arrive during conversions do not change when `adcRd` occurs.
- R9: `adcWr` and `adcRd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sampleTick | input | 1 | One-cycle sample-rate enable pulse |
| streamMode | input | 1 | 1 inserts the settle wait before each read |
| adcIntN | input | 1 | Asynchronous active-low end-of-conversion interrupt |
| adcData | input | 8 | Converter data bus |
| adcWr | output | 1 | Start/write strobe to the converter |
| adcRd | output | 1 | Read strobe to the converter |
| sampleOut | output | 8 | Last captured byte, bit-reversed |
| sampleValid | output | 1 | One-cycle pulse marking a new byte |

## Verification
The hardest case to reach is a mode switch between back-to-back conversions. The bench must show that the settle wait appears or disappears exactly on the next read, and that stray ticks landing mid-conversion leave the read timing alone. A behavioural converter model in the bench asserts the interrupt after a varying delay. It computes each read cycle from the cycle where it drove the interrupt low. The stimulus flips `streamMode` right after a read and fires extra ticks while conversions run. It also feeds the bit patterns 0x01 and 0x80 to expose the reversal.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CONV   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_READ   = 2'd3
  } seqState_t;

  typedef struct packed {
    logic writeStrobe;
    logic readStrobe;
  } seqStrobes_t;
endpackage

// File: rtl/adcseq_datapath.sv
module adcseq_datapath
  import adcseq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic              adcIntN,
  input  logic [DATA_W-1:0] adcData,
  output logic              intFall,
  output logic [DATA_W-1:0] sampleOut,
  output logic              sampleValid
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   intLast;
  logic [DATA_W-1:0]      revData;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[i] <= 1'b1;
        else       syncQ[i] <= adcIntN;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ[i] <= 1'b1;
        else       syncQ[i] <= syncQ[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) intLast <= 1'b1;
    else       intLast <= syncQ[LAST];

  assign intFall = intLast & ~syncQ[LAST];

  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign revData[b] = adcData[DATA_W-1-b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobes.readStrobe;
      if (strobes.readStrobe) sampleOut <= revData;
    end
  end

  AST_REVERSED_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.readStrobe |=> (sampleOut[0] == $past(adcData[DATA_W-1]) &&
                            sampleOut[DATA_W-1] == $past(adcData[0]))); // R6
  AST_VALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    strobes.readStrobe |=> sampleValid); // R7
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !strobes.readStrobe) |=> !sampleValid); // R7
endmodule

// File: rtl/adcseq_control.sv
module adcseq_control
  import adcseq_pkg::*;
#(
  parameter int WAIT_CYCLES = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleTick,
  input  logic        streamMode,
  input  logic        intFall,
  output seqStrobes_t strobes
);
  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES - 1);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] waitCnt;
  logic             pendingReq;
  logic             leaveIdle;

  assign leaveIdle = (state == ST_IDLE) && pendingReq;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) pendingReq <= 1'b0;
    else       pendingReq <= (pendingReq & ~leaveIdle) | sampleTick;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (pendingReq) stateNext = ST_CONV;
      ST_CONV:   if (intFall) stateNext = streamMode ? ST_SETTLE : ST_READ;
      ST_SETTLE: if (waitCnt == CNT_LAST) stateNext = ST_READ;
      ST_READ:   stateNext = ST_CONV;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_SETTLE) waitCnt <= waitCnt + 1'b1;
      else                    waitCnt <= '0;
    end
  end

  always_comb begin
    strobes = '0;
    case (state)
      ST_IDLE:   begin strobes.writeStrobe = 1'b0; strobes.readStrobe = 1'b0; end
      ST_CONV:   begin strobes.writeStrobe = 1'b1; strobes.readStrobe = 1'b0; end
      ST_SETTLE: begin strobes.writeStrobe = 1'b0; strobes.readStrobe = 1'b0; end
      ST_READ:   begin strobes.writeStrobe = 1'b0; strobes.readStrobe = 1'b1; end
      default:   strobes = '0;
    endcase
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !pendingReq) |=> state == ST_IDLE); // R1
  AST_CONV_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && !intFall) |=> state == ST_CONV); // R3
  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SETTLE |-> waitCnt < CNT_W'(WAIT_CYCLES)); // R4
  AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_READ |=> state == ST_CONV); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.writeStrobe && strobes.readStrobe)); // R9
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import adcseq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int WAIT_CYCLES = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              streamMode,
  input  logic              adcIntN,
  input  logic [DATA_W-1:0] adcData,
  output logic              adcWr,
  output logic              adcRd,
  output logic [DATA_W-1:0] sampleOut,
  output logic              sampleValid
);
  seqStrobes_t strobes;
  logic        intFall;

  adcseq_control #(.WAIT_CYCLES(WAIT_CYCLES)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .streamMode (streamMode),
    .intFall    (intFall),
    .strobes    (strobes)
  );

  adcseq_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .adcIntN     (adcIntN),
    .adcData     (adcData),
    .intFall     (intFall),
    .sampleOut   (sampleOut),
    .sampleValid (sampleValid)
  );

  assign adcWr = strobes.writeStrobe;
  assign adcRd = strobes.readStrobe;
endmodule

// File: tb/adc_conv_sequencer_bench.sv
module adc_conv_sequencer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       streamMode = 1'b0;
  logic       adcIntN = 1'b1;
  logic [7:0] adcData = 8'h00;
  logic       adcWr, adcRd, sampleValid;
  logic [7:0] sampleOut;

  adc_conv_sequencer u_adc_conv_sequencer (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .streamMode(streamMode),
    .adcIntN(adcIntN), .adcData(adcData), .adcWr(adcWr), .adcRd(adcRd),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int edgeCount = 0;
  int rdDue = -1, validDue = -1, waitFrom = -1, lastRd = -100, startDue = -1;
  int convCount = 0;
  int countdown = 0;
  bit busy = 0;
  bit started = 0;
  bit modelOn = 0;
  logic [7:0] expQ[$];

  always @(posedge clk) edgeCount <= edgeCount + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at edge %0d", req, act, exp, edgeCount);
    end
  endtask

  function automatic logic [7:0] nextByte(input int idx);
    case (idx)
      0: return 8'h01;
      1: return 8'h80;
      2: return 8'hF0;
      default: return 8'((idx * 37 + 11) & 255);
    endcase
  endfunction

  function automatic logic [7:0] reverse8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  // behavioural converter and per-cycle comparison
  always @(negedge clk) begin
    if (modelOn) begin
      check(adcRd == (edgeCount == rdDue), "R3/R4 read timing", adcRd, edgeCount == rdDue);
      check(sampleValid == (edgeCount == validDue), "R7 valid timing", sampleValid,
            edgeCount == validDue);
      check(!(adcWr && adcRd), "R9 strobe exclusion", {adcWr, adcRd}, 2'b00);
      if (!started) check(adcWr == 1'b0, "R1 idle without request", adcWr, 0);
      if (edgeCount == startDue) check(adcWr == 1'b1, "R2 start after tick", adcWr, 1);
      if (waitFrom >= 0 && edgeCount >= waitFrom && edgeCount <= rdDue)
        check(adcWr == 1'b0, "R4 write low in settle/read", adcWr, 0);
      if (edgeCount == lastRd + 1) begin
        check(adcWr == 1'b1, "R5 restart after read", adcWr, 1);
        check(adcRd == 1'b0, "R5 single read cycle", adcRd, 0);
      end
      if (sampleValid) begin
        if (expQ.size() == 0) check(1'b0, "R7 unexpected valid", sampleOut, 0);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(sampleOut == e, "R6 reversed byte", sampleOut, e);
        end
      end
      if (adcRd) begin
        expQ.push_back(reverse8(adcData));
        validDue = edgeCount + 1;
        lastRd = edgeCount;
        adcIntN = 1'b1;
        busy = 0;
        convCount++;
      end else if (!busy && adcWr && adcIntN) begin
        busy = 1;
        countdown = 3 + (convCount % 3) * 3;
      end else if (busy && adcIntN) begin
        countdown--;
        if (countdown == 0) begin
          adcIntN = 1'b0;
          adcData = nextByte(convCount);
          waitFrom = edgeCount + 3;
          rdDue = edgeCount + 3 + (streamMode ? 10 : 0);
          if (!streamMode) waitFrom = rdDue;
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired convCount=%0d expected=12", convCount);
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(adcWr == 0 && adcRd == 0, "R1 reset strobes", {adcWr, adcRd}, 0);
    check(sampleValid == 0 && sampleOut == 0, "R1 reset output", sampleOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    modelOn = 1;
    repeat (20) @(negedge clk);
    check(adcWr == 0, "R1 still idle", adcWr, 0);
    // tick high across edge t0+1; pending at t0+1; convert at t0+2
    sampleTick = 1'b1;
    startDue = edgeCount + 2;
    @(negedge clk);
    sampleTick = 1'b0;
    started = 1;
    wait (convCount == 2);
    tick();                    // R8: tick during conversion, no effect
    wait (convCount == 4);
    @(negedge clk);
    streamMode = 1'b1;         // R4 settle wait from next read
    wait (convCount == 6);
    tick();                    // R8
    wait (convCount == 8);
    @(negedge clk);
    streamMode = 1'b0;
    wait (convCount == 12);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R8 every read produced a byte", expQ.size(), 0);
    check(convCount == 12, "R8 free-running conversions", convCount, 12);
    finishRun();
  end
endmodule